// File: doc/BRIEF.md
# Memory Bank Mapping Controller

This block sits between an 8-bit CPU's 16-bit memory bus and four memories: main RAM, boot ROM, a 4 KB video RAM and a 4 KB glyph RAM that holds high-resolution character patterns. For every memory access it picks one target, raises that target's chip select and hands it a translated offset. Reads and writes to one address window are steered independently. The CPU can therefore run code out of ROM while writes to the same addresses land in RAM, video memory or glyph memory.

A system control byte sets the routing. The CPU writes this byte through an I/O port. One bit selects a flat all-RAM mode, which overrides every other routing choice. A second bit decides whether writes to the 0x4000 window reach glyph RAM or main RAM. A third bit selects the clock rate for the video timing generator.

An I/O read returns a status byte. This byte is the stored control byte with some bits masked, plus the live vertical sync level. The block holds only the control register. All routing is combinational from the address, the strobes and that register.

Top module: `bank_map_ctrl`

## Requirements
- R1: Any access to 0x5000-0xFFFF selects main RAM with ram_addr equal to cpu_addr, in every mode.
- R2: When control bit 1 is 1, reads and writes to 0x0000-0x4FFF select main RAM with ram_addr equal to cpu_addr, whatever bit 0 holds.
- R3: With bit 1 at 0, reads are routed to ROM with these offsets: 0x0000-0x1FFF reads ROM at cpu_addr; 0x2000-0x2FFF reads ROM at 0x4000 + (cpu_addr - 0x2000); 0x3000-0x3FFF reads ROM at 0x5000 + (cpu_addr - 0x3000).
- R4: With bit 1 at 0, reads of 0x4000-0x4FFF select main RAM at cpu_addr.
- R5: With bit 1 at 0, writes are routed as follows: 0x0000-0x1FFF writes main RAM at cpu_addr; 0x2000-0x2FFF writes video RAM at cpu_addr - 0x2000; 0x3000-0x3FFF writes glyph RAM at cpu_addr - 0x3000.
- R6: With bit 1 at 0, writes to 0x4000-0x4FFF depend on bit 0. If bit 0 is 1 they select glyph RAM at cpu_addr - 0x4000. If bit 0 is 0 they select main RAM at cpu_addr.
- R7: Whenever mem_rd or mem_wr is high, exactly one of ram_cs, rom_cs, vid_cs, gly_cs is high. When both strobes are low, none is high. rom_cs is never high during a write.
- R8: vclk_fast equals control bit 2. A value of 1 selects the 2 MHz video clock and 0 selects the 1 MHz clock.
- R9: While io_rd is high, io_rdata equals (control & 0x2F) with bit 4 replaced by vsync. Stored bits 4, 6 and 7 are therefore hidden. While io_rd is low, io_rdata is 0x00.
- R10: Reset sets the control byte to 0x01. After reset, ROM is readable at 0x0000-0x3FFF and writes to 0x4000-0x4FFF reach glyph RAM.
- R11: An io_wr pulse loads io_wdata into the control byte at that clock edge, and the new routing applies from the next cycle. Without io_wr, the control byte holds its value, whatever io_wdata does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | Control port write strobe |
| io_rd | input | 1 | Status port read strobe |
| io_wdata | input | 8 | Data for the control byte |
| vsync | input | 1 | Vertical sync level from the CRT controller |
| io_rdata | output | 8 | Status byte |
| ram_cs | output | 1 | Main RAM select |
| ram_addr | output | 16 | Main RAM offset |
| rom_cs | output | 1 | ROM select |
| rom_addr | output | 15 | ROM offset |
| vid_cs | output | 1 | Video RAM select |
| vid_addr | output | 12 | Video RAM offset |
| gly_cs | output | 1 | Glyph RAM select |
| gly_addr | output | 12 | Glyph RAM offset |
| vclk_fast | output | 1 | Video clock select, 1 for 2 MHz |

## Verification
The assertions assume that mem_rd and mem_wr are never high together, because one bus cycle is either a read or a write. That assumption is checked as an assertion of its own. The chip-select checks also take it for granted that cpu_addr is stable while a strobe is high. The bench drives each access for a single cycle with only one strobe raised. It changes the control byte only between accesses, with idle strobes, so every access sees a settled mode.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  localparam int ADDR_W   = 16;
  localparam int CTRL_W   = 8;
  localparam int ROM_AW   = 15;
  localparam int SMALL_AW = 12;
  localparam int NWIN     = 4;

  // control byte fields
  localparam int CB_GLYW = 0;
  localparam int CB_FLAT = 1;
  localparam int CB_VCLK = 2;
  localparam int VS_BIT  = 4;
  localparam logic [CTRL_W-1:0] STATUS_MASK = 8'h2F;
  localparam logic [CTRL_W-1:0] CTRL_RST    = 8'h01;

  typedef enum logic [1:0] {TGT_RAM, TGT_ROM, TGT_VID, TGT_GLY} tgt_e;

  localparam logic [ADDR_W-1:0] WIN_LO [0:NWIN-1] = '{16'h0000, 16'h2000, 16'h3000, 16'h4000};
  localparam logic [ADDR_W-1:0] WIN_HI [0:NWIN-1] = '{16'h1FFF, 16'h2FFF, 16'h3FFF, 16'h4FFF};
  localparam logic [ADDR_W-1:0] ROM_BASE [0:NWIN-1] = '{16'h0000, 16'h4000, 16'h5000, 16'h0000};

  localparam tgt_e RD_TGT    [0:NWIN-1] = '{TGT_ROM, TGT_ROM, TGT_ROM, TGT_RAM};
  localparam tgt_e WR_TGT_G  [0:NWIN-1] = '{TGT_RAM, TGT_VID, TGT_GLY, TGT_GLY};
  localparam tgt_e WR_TGT_NG [0:NWIN-1] = '{TGT_RAM, TGT_VID, TGT_GLY, TGT_RAM};

  function automatic tgt_e pick_target(input logic flat, input logic glyw,
                                       input logic [NWIN-1:0] hit, input logic is_wr);
    tgt_e t;
    t = TGT_RAM;
    if (!flat) begin
      for (int i = 0; i < NWIN; i++) begin
        if (hit[i]) begin
          if (!is_wr)    t = RD_TGT[i];
          else if (glyw) t = WR_TGT_G[i];
          else           t = WR_TGT_NG[i];
        end
      end
    end
    return t;
  endfunction

  function automatic logic [ROM_AW-1:0] rom_offset(input logic [ADDR_W-1:0] a,
                                                   input logic [NWIN-1:0] hit);
    logic [ADDR_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (hit[i]) acc = acc | (ROM_BASE[i] + (a & (WIN_HI[i] - WIN_LO[i])));
    end
    return acc[ROM_AW-1:0];
  endfunction

  function automatic logic [CTRL_W-1:0] status_byte(input logic [CTRL_W-1:0] c,
                                                    input logic vs);
    logic [CTRL_W-1:0] s;
    s = c & STATUS_MASK;
    s[VS_BIT] = vs;
    return s;
  endfunction

endpackage

// File: rtl/bank_ctrl_reg.sv
module bank_ctrl_reg
  import bank_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [CTRL_W-1:0] io_wdata,
  input  logic              vsync,
  output logic [CTRL_W-1:0] io_rdata,
  output logic              mode_flat,
  output logic              mode_glyw,
  output logic              vclk_sel
);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= CTRL_RST;
    else if (io_wr) ctrl_q <= io_wdata;
  end

  assign mode_flat = ctrl_q[CB_FLAT];
  assign mode_glyw = ctrl_q[CB_GLYW];
  assign vclk_sel  = ctrl_q[CB_VCLK];

  always_comb begin
    io_rdata = '0;
    if (io_rd) io_rdata = status_byte(ctrl_q, vsync);
  end

  assert_ctrl_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> ctrl_q == $past(io_wdata));

  assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(ctrl_q));

  assert_status_vs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |-> io_rdata[VS_BIT] == vsync && io_rdata[7:6] == 2'b00);

endmodule

// File: rtl/bank_win_decode.sv
module bank_win_decode
  import bank_map_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [NWIN-1:0]   win_hit
);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign win_hit[g] = (addr >= WIN_LO[g]) && (addr <= WIN_HI[g]);
  end

endmodule

// File: rtl/bank_route.sv
module bank_route
  import bank_map_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NWIN-1:0]     win_hit,
  input  logic                active,
  input  logic                is_wr,
  input  logic                flat,
  input  logic                glyw,
  output logic [3:0]          cs_vec,
  output logic [ROM_AW-1:0]   rom_off,
  output logic [SMALL_AW-1:0] small_off
);

  tgt_e tgt;

  assign tgt       = pick_target(flat, glyw, win_hit, is_wr);
  assign rom_off   = rom_offset(addr, win_hit);
  assign small_off = addr[SMALL_AW-1:0];

  // cs_vec bit order follows tgt_e encoding: 0 RAM, 1 ROM, 2 video, 3 glyph
  always_comb begin
    cs_vec = '0;
    if (active) cs_vec[tgt] = 1'b1;
  end

endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bank_map_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                mem_rd,
  input  logic                mem_wr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [CTRL_W-1:0]   io_wdata,
  input  logic                vsync,
  output logic [CTRL_W-1:0]   io_rdata,
  output logic                ram_cs,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic                rom_cs,
  output logic [ROM_AW-1:0]   rom_addr,
  output logic                vid_cs,
  output logic [SMALL_AW-1:0] vid_addr,
  output logic                gly_cs,
  output logic [SMALL_AW-1:0] gly_addr,
  output logic                vclk_fast
);

  logic                mode_flat;
  logic                mode_glyw;
  logic [NWIN-1:0]     win_hit;
  logic                bus_active;
  logic [3:0]          cs_vec;
  logic [ROM_AW-1:0]   rom_off;
  logic [SMALL_AW-1:0] small_off;

  assign bus_active = mem_rd | mem_wr;

  bank_ctrl_reg i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .vsync     (vsync),
    .io_rdata  (io_rdata),
    .mode_flat (mode_flat),
    .mode_glyw (mode_glyw),
    .vclk_sel  (vclk_fast)
  );

  bank_win_decode i_dec (
    .addr    (cpu_addr),
    .win_hit (win_hit)
  );

  bank_route i_route (
    .addr      (cpu_addr),
    .win_hit   (win_hit),
    .active    (bus_active),
    .is_wr     (mem_wr),
    .flat      (mode_flat),
    .glyw      (mode_glyw),
    .cs_vec    (cs_vec),
    .rom_off   (rom_off),
    .small_off (small_off)
  );

  assign ram_cs   = cs_vec[TGT_RAM];
  assign rom_cs   = cs_vec[TGT_ROM];
  assign vid_cs   = cs_vec[TGT_VID];
  assign gly_cs   = cs_vec[TGT_GLY];
  assign ram_addr = cpu_addr;
  assign rom_addr = rom_off;
  assign vid_addr = small_off;
  assign gly_addr = small_off;

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_one_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |-> $countones({ram_cs, rom_cs, vid_cs, gly_cs}) == 1);

  assert_idle_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> !(ram_cs || rom_cs || vid_cs || gly_cs));

  assert_no_rom_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !rom_cs);

  assert_upper_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && cpu_addr >= 16'h5000) |-> ram_cs);

  assert_flat_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && mode_flat) |-> ram_cs);

  assert_rom_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mode_flat && cpu_addr < 16'h4000) |-> rom_cs);

  assert_glyph_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mode_flat && cpu_addr[15:12] == 4'h4) |-> (gly_cs == mode_glyw));

endmodule

// File: tb/test_bank_map_ctrl.sv
`timescale 1ns/1ps
module test_bank_map_ctrl;

  typedef struct {
    string       tag;
    int          kind;   // 0 access, 1 status
    logic [3:0]  cs;     // {gly, vid, rom, ram}
    logic [15:0] off;
    logic [7:0]  st;
    logic        vclk;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0, io_wr = 1'b0, io_rd = 1'b0, vsync = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        ram_cs, rom_cs, vid_cs, gly_cs, vclk_fast;
  logic [15:0] ram_addr;
  logic [14:0] rom_addr;
  logic [11:0] vid_addr, gly_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model_ctrl;
  item_t q[$];

  always #2.5 clk = ~clk;

  bank_map_ctrl i_bank_map_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .vsync(vsync), .io_rdata(io_rdata),
    .ram_cs(ram_cs), .ram_addr(ram_addr), .rom_cs(rom_cs), .rom_addr(rom_addr),
    .vid_cs(vid_cs), .vid_addr(vid_addr), .gly_cs(gly_cs), .gly_addr(gly_addr),
    .vclk_fast(vclk_fast)
  );

  // independent model of the routing rules
  function automatic item_t model_access(logic [7:0] c, logic [15:0] a, bit wr);
    item_t it;
    it.kind = 0; it.st = '0; it.vclk = c[2];
    it.cs = 4'b0001; it.off = a;
    if (a >= 16'h5000)  it.tag = "R1";
    else if (c[1])      it.tag = "R2";
    else if (!wr) begin
      if (a < 16'h2000)      begin it.tag = "R3"; it.cs = 4'b0010; it.off = a; end
      else if (a < 16'h3000) begin it.tag = "R3"; it.cs = 4'b0010; it.off = a - 16'h2000 + 16'h4000; end
      else if (a < 16'h4000) begin it.tag = "R3"; it.cs = 4'b0010; it.off = a - 16'h3000 + 16'h5000; end
      else                         it.tag = "R4";
    end else begin
      if (a < 16'h2000)      it.tag = "R5";
      else if (a < 16'h3000) begin it.tag = "R5"; it.cs = 4'b0100; it.off = a - 16'h2000; end
      else if (a < 16'h4000) begin it.tag = "R5"; it.cs = 4'b1000; it.off = a - 16'h3000; end
      else begin
        it.tag = "R6";
        if (c[0]) begin it.cs = 4'b1000; it.off = a - 16'h4000; end
      end
    end
    return it;
  endfunction

  task automatic set_ctrl(logic [7:0] v);
    @(posedge clk); #1;
    mem_rd = 0; mem_wr = 0; io_rd = 0;
    io_wr = 1; io_wdata = v;
    @(posedge clk); #1;
    io_wr = 0;
    model_ctrl = v;
  endtask

  task automatic do_access(logic [15:0] a, bit wr);
    @(posedge clk); #1;
    io_rd = 0; cpu_addr = a; mem_wr = wr; mem_rd = !wr;
    q.push_back(model_access(model_ctrl, a, wr));
  endtask

  task automatic do_idle(string tag);
    item_t it;
    @(posedge clk); #1;
    mem_rd = 0; mem_wr = 0; io_rd = 0;
    it.tag = tag; it.kind = 0; it.cs = 4'b0000; it.off = '0; it.st = '0; it.vclk = model_ctrl[2];
    q.push_back(it);
  endtask

  task automatic do_status(bit vs, bit rd, string tag);
    item_t it;
    @(posedge clk); #1;
    mem_rd = 0; mem_wr = 0; vsync = vs; io_rd = rd;
    it.tag = tag; it.kind = 1; it.cs = '0; it.off = '0; it.vclk = model_ctrl[2];
    it.st = rd ? {2'b00, model_ctrl[5], vs, model_ctrl[3:0]} : 8'h00;
    q.push_back(it);
  endtask

  // monitor: compares outputs half a cycle after the driver applies them
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [3:0]  cs_act;
        logic [15:0] off_act;
        it = q.pop_front();
        cs_act = {gly_cs, vid_cs, rom_cs, ram_cs};
        checks++;
        if (it.kind == 1) begin
          if (io_rdata !== it.st || vclk_fast !== it.vclk) begin
            errors++;
            $display("FAIL %s status act=%02h/%0b exp=%02h/%0b", it.tag, io_rdata, vclk_fast, it.st, it.vclk);
          end
        end else begin
          case (it.cs)
            4'b0001: off_act = ram_addr;
            4'b0010: off_act = {1'b0, rom_addr};
            4'b0100: off_act = {4'b0, vid_addr};
            4'b1000: off_act = {4'b0, gly_addr};
            default: off_act = '0;
          endcase
          if (cs_act !== it.cs || off_act !== it.off) begin
            errors++;
            $display("FAIL %s addr=%04h cs act=%b exp=%b off act=%04h exp=%04h",
                     it.tag, cpu_addr, cs_act, it.cs, off_act, it.off);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [12] = '{16'h0000, 16'h1234, 16'h1FFF, 16'h2000, 16'h2ABC, 16'h2FFF,
                                16'h3000, 16'h3FFF, 16'h4000, 16'h4FFF, 16'h5000, 16'hFFFF};
    logic [7:0]  modes [4]  = '{8'h00, 8'h01, 8'h02, 8'h03};
    model_ctrl = 8'h01;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10: reset value and reset routing
    do_status(1'b0, 1'b1, "R10");
    do_access(16'h4123, 1'b1);
    do_access(16'h2345, 1'b0);
    // R1..R6 under every mode combination of bits 1:0
    foreach (modes[m]) begin
      set_ctrl(modes[m]);
      foreach (addrs[k]) begin
        do_access(addrs[k], 1'b0);
        do_access(addrs[k], 1'b1);
      end
    end
    // R7: idle strobes select nothing
    do_idle("R7");
    // R8: clock select
    set_ctrl(8'h04);
    do_status(1'b0, 1'b1, "R8");
    set_ctrl(8'h00);
    do_status(1'b0, 1'b1, "R8");
    // R9: masking and vsync insertion
    set_ctrl(8'hFF);
    do_status(1'b1, 1'b1, "R9");
    do_status(1'b0, 1'b1, "R9");
    do_status(1'b1, 1'b0, "R9");
    set_ctrl(8'hD0);
    do_status(1'b0, 1'b1, "R9");
    // R11: io_wdata alone does not change the control byte
    @(posedge clk); #1 io_wdata = 8'h2F;
    repeat (3) @(posedge clk);
    do_status(1'b0, 1'b1, "R11");
    do_access(16'h1000, 1'b0);
    do_idle("R7");
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule